// File: doc/BRIEF.md
# Stream Handshake Profiler

This block sits beside a valid/ready stream and watches it passively. It takes the stream's valid, ready, last and per-beat element count as inputs only, so the monitored link keeps its timing unchanged. While profiling is switched on, six saturating counters record how the stream behaves. One counts beats offered. One counts cycles in which the sink could accept. One counts accepted beats. One counts accepted beats that end a packet. One sums the elements carried by accepted beats. The last counts the clock cycles spent profiling.

Software reaches the block through a small word-addressed register port. The write side sets or drops the enable bit and fires a clear pulse. The read side is a combinational mux over the enable bit and the six counters. One instance watches exactly one stream. The counter width and the largest element count per beat are parameters.

Top module: `stream_profiler`

## Requirements
- R1: After reset the enable bit reads 0 at word 0 and all six counters read 0.
- R2: A write to word 0 loads bit 0 of the write data into the enable bit, which reads back at word 0 bit 0. Counting starts or stops from the first clock edge after the write edge.
- R3: A write to word 1 with bit 0 set zeroes all six counters at the write edge, even if counting would have happened in that cycle. A write to word 1 with bit 0 clear has no effect. Word 1 always reads 0.
- R4: While the enable bit is 0, no counter changes, whatever the stream does.
- R5: Word 2 (elements) adds the beat's element count on every edge where valid and ready are both 1.
- R6: Word 3 (valids) counts edges where valid is 1. Word 4 (readies) counts edges where ready is 1.
- R7: Word 5 (transfers) counts edges where valid and ready are both 1.
- R8: Word 6 (packets) counts edges where valid, ready and last are all 1. A last seen without a handshake is not counted.
- R9: Word 7 (cycles) counts every edge at which the enable bit is 1.
- R10: Every counter stops at all-ones and stays there instead of wrapping. An addition that would pass all-ones also ends at all-ones.
- R11: An element count above MAX_BEAT is treated as MAX_BEAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Observed stream valid |
| mon_ready | input | 1 | Observed stream ready |
| mon_last | input | 1 | Observed end-of-packet marker |
| mon_count | input | INC_W | Elements carried by the observed beat |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read word address |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_raddr |

## Verification
A stream event present before a clock edge shows up in the counters right after that edge, so the read port gives the new value within the same low clock phase. The bench drives each beat for exactly one edge and reads all eight words before the next edge. A register write takes effect at its own edge. Clearing acts on the counters at that edge. Enabling only affects counting from the following edge, and the bench's expected cycle counts add that edge only when the enable bit was already set.

// File: rtl/prof_pkg.sv
package prof_pkg;

    localparam int unsigned NUM_CNT   = 6;

    localparam int unsigned IDX_ELEM  = 0;
    localparam int unsigned IDX_VALID = 1;
    localparam int unsigned IDX_READY = 2;
    localparam int unsigned IDX_XFER  = 3;
    localparam int unsigned IDX_PKT   = 4;
    localparam int unsigned IDX_CYC   = 5;

    localparam logic [2:0] OFS_EN   = 3'd0;
    localparam logic [2:0] OFS_CLR  = 3'd1;
    localparam logic [2:0] OFS_CNT0 = 3'd2;

    typedef struct packed {
        logic en;
    } ctl_t;

endpackage

// File: rtl/prof_event_tap.sv
module prof_event_tap
    import prof_pkg::*;
#(
    parameter int unsigned INC_W    = 3,
    parameter int unsigned MAX_BEAT = 4
) (
    input  logic                            valid,
    input  logic                            ready,
    input  logic                            last,
    input  logic [INC_W-1:0]                count,
    output logic [NUM_CNT-1:0][INC_W-1:0]   inc
);

    logic             hs;
    logic [INC_W-1:0] clamped;

    always_comb begin
        hs      = valid & ready;
        clamped = (count > INC_W'(MAX_BEAT)) ? INC_W'(MAX_BEAT) : count;

        inc            = '0;
        inc[IDX_ELEM]  = hs ? clamped : '0;
        inc[IDX_VALID] = INC_W'(valid);
        inc[IDX_READY] = INC_W'(ready);
        inc[IDX_XFER]  = INC_W'(hs);
        inc[IDX_PKT]   = INC_W'(hs & last);
        inc[IDX_CYC]   = INC_W'(1'b1);
    end

endmodule

// File: rtl/prof_sat_counter.sv
module prof_sat_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

endmodule

// File: rtl/stream_profiler.sv
module stream_profiler
    import prof_pkg::*;
#(
    parameter  int unsigned CNT_W    = 32,
    parameter  int unsigned MAX_BEAT = 4,
    localparam int unsigned INC_W    = $clog2(MAX_BEAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic              mon_ready,
    input  logic              mon_last,
    input  logic [INC_W-1:0]  mon_count,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_waddr,
    input  logic [31:0]       cfg_wdata,
    input  logic [2:0]        cfg_raddr,
    output logic [31:0]       cfg_rdata
);

    ctl_t ctl_d, ctl_q;
    logic clr_pulse;

    logic [NUM_CNT-1:0][INC_W-1:0] inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    always_comb begin
        ctl_d     = ctl_q;
        clr_pulse = 1'b0;
        if (cfg_we && cfg_waddr == OFS_EN) begin
            ctl_d.en = cfg_wdata[0];
        end
        if (cfg_we && cfg_waddr == OFS_CLR) begin
            clr_pulse = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    prof_event_tap #(
        .INC_W    (INC_W),
        .MAX_BEAT (MAX_BEAT)
    ) tap_i (
        .valid (mon_valid),
        .ready (mon_ready),
        .last  (mon_last),
        .count (mon_count),
        .inc   (inc)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        prof_sat_counter #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_pulse),
            .en    (ctl_q.en),
            .inc   (inc[g]),
            .value (cnt_val[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_raddr == OFS_EN) begin
            cfg_rdata = {31'b0, ctl_q.en};
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cfg_raddr == OFS_CNT0 + 3'(i)) begin
                cfg_rdata = 32'(cnt_val[i]);
            end
        end
    end

endmodule

// File: rtl/prof_chk.sv
module prof_chk
    import prof_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en,
    input logic                          clr,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R9
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt[IDX_CYC] != '1) |=> (cnt[IDX_CYC] == $past(cnt[IDX_CYC]) + 1'b1));

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt[IDX_ELEM] == '1) |=> (cnt[IDX_ELEM] == '1));

    // R7
    xfer_le_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[IDX_XFER] <= cnt[IDX_VALID]);

    // R8
    pkt_le_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[IDX_PKT] <= cnt[IDX_XFER]);

endmodule

bind stream_profiler prof_chk #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl_q.en),
    .clr   (clr_pulse),
    .cnt   (cnt_val)
);

// File: tb/stream_profiler_tb.sv
module stream_profiler_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int CW         = 8;
    localparam int MB         = 4;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 1'b0, mon_ready = 1'b0, mon_last = 1'b0;
    logic [IW-1:0] mon_count = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_waddr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [2:0]    cfg_raddr = '0;
    logic [31:0]   cfg_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_profiler #(.CNT_W(CW), .MAX_BEAT(MB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(mon_valid), .mon_ready(mon_ready), .mon_last(mon_last),
        .mon_count(mon_count),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
    );

    typedef struct packed {
        logic v, r, l;
        logic [2:0] c;
        logic [7:0] de, dv, dr, dx, dp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 1'b0, 3'd3, 8'd3, 8'd1, 8'd1, 8'd1, 8'd0},
        '{1'b1, 1'b0, 1'b1, 3'd2, 8'd0, 8'd1, 8'd0, 8'd0, 8'd0},
        '{1'b0, 1'b1, 1'b1, 3'd4, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0},
        '{1'b1, 1'b1, 1'b1, 3'd4, 8'd4, 8'd1, 8'd1, 8'd1, 8'd1},
        '{1'b1, 1'b1, 1'b0, 3'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0},
        '{1'b0, 1'b0, 1'b0, 3'd4, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
        '{1'b1, 1'b1, 1'b1, 3'd7, 8'd4, 8'd1, 8'd1, 8'd1, 8'd1},
        '{1'b1, 1'b1, 1'b0, 3'd5, 8'd4, 8'd1, 8'd1, 8'd1, 8'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic beat(input logic v, input logic r, input logic l, input logic [IW-1:0] c);
        mon_valid = v; mon_ready = r; mon_last = l; mon_count = c;
        tick();
        mon_valid = 1'b0; mon_ready = 1'b0; mon_last = 1'b0; mon_count = '0;
    endtask

    task automatic chk_cnts(input string ctx, input int e, input int v, input int r,
                            input int x, input int p, input int cy);
        logic [31:0] d;
        rd(3'd2, d); chk({"R5 elements ", ctx}, d, 32'(e));
        rd(3'd3, d); chk({"R6 valids ", ctx}, d, 32'(v));
        rd(3'd4, d); chk({"R6 readies ", ctx}, d, 32'(r));
        rd(3'd5, d); chk({"R7 transfers ", ctx}, d, 32'(x));
        rd(3'd6, d); chk({"R8 packets ", ctx}, d, 32'(p));
        rd(3'd7, d); chk({"R9 cycles ", ctx}, d, 32'(cy));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e, v, r, x, p, cy;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, d); chk("R1 enable after reset", d, 32'd0);
        chk_cnts("R1 after reset", 0, 0, 0, 0, 0, 0);

        // R4 traffic while disabled
        repeat (4) beat(1'b1, 1'b1, 1'b1, 3'd4);
        chk_cnts("R4 disabled traffic", 0, 0, 0, 0, 0, 0);

        // R2 enable write, effective from the next edge
        wr(3'd0, 32'd1);
        rd(3'd0, d); chk("R2 enable readback", d, 32'd1);
        rd(3'd7, d); chk("R2 no count at enable edge", d, 32'd0);

        // table walk (R5..R9, R11 in vector 6)
        e = 0; v = 0; r = 0; x = 0; p = 0; cy = 0;
        for (int i = 0; i < 8; i++) begin
            beat(VECS[i].v, VECS[i].r, VECS[i].l, VECS[i].c);
            e += int'(VECS[i].de); v += int'(VECS[i].dv); r += int'(VECS[i].dr);
            x += int'(VECS[i].dx); p += int'(VECS[i].dp); cy += 1;
            chk_cnts($sformatf("vector %0d", i), e, v, r, x, p, cy);
        end

        // R11 single clamped beat on top of table totals
        beat(1'b1, 1'b1, 1'b0, 3'd6);
        rd(3'd2, d); chk("R11 clamp of count 6", d, 32'(e + MB));

        // R3 clear has priority over a handshake in the same cycle
        mon_valid = 1'b1; mon_ready = 1'b1; mon_last = 1'b1; mon_count = 3'd4;
        wr(3'd1, 32'd1);
        mon_valid = 1'b0; mon_ready = 1'b0; mon_last = 1'b0; mon_count = '0;
        chk_cnts("R3 clear with traffic", 0, 0, 0, 0, 0, 0);
        rd(3'd1, d); chk("R3 clear word reads 0", d, 32'd0);

        // R2 disable: edge of the write still counts one idle cycle
        wr(3'd0, 32'd0);
        rd(3'd0, d); chk("R2 enable cleared readback", d, 32'd0);
        repeat (3) beat(1'b1, 1'b1, 1'b1, 3'd3);
        chk_cnts("R4 disabled after run", 0, 0, 0, 0, 0, 1);

        // R10 saturation
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd1);
        mon_valid = 1'b1; mon_ready = 1'b1; mon_last = 1'b1; mon_count = 3'd4;
        repeat (300) tick();
        mon_valid = 1'b0; mon_ready = 1'b0; mon_last = 1'b0; mon_count = '0;
        chk_cnts("R10 saturated", 255, 255, 255, 255, 255, 255);

        // R3 clear write with bit 0 low is ignored
        wr(3'd1, 32'hFFFF_FFFE);
        chk_cnts("R3 clear bit0 low ignored", 255, 255, 255, 255, 255, 255);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule